// File: doc/BRIEF.md
# Banked memory paging unit

This block sits between a CPU with a 64K address space and a larger physical memory. It turns each CPU address into a physical RAM address, a ROM address or an external-memory address. Two paging schemes are stacked. A home scheme gives ROM in the lowest 16K, two fixed RAM banks in the middle and a switchable 16K bank at the top, with a ROM choice between a boot image and a BASIC image. Over that, an overlay scheme can replace any of the eight 8K CPU pages with the same-numbered page from one of two overlay banks.

Paging state lives in three byte-wide registers. The CPU writes them over the I/O bus and reads each one back unchanged. The register that holds the home settings also selects which of two RAM banks the video fetcher reads. Overlay changes never touch that selection. An external override line can hand the lowest 16K to outside memory, and writes aimed at ROM are suppressed.

Top module: `bank_pager`

## Requirements
- R1: Register writes are decoded on the full 16-bit port address: 0x00F4 is the overlay register, 0x00FF is the control register and 0x7FFD is the home register. A write to any other port, such as 0x01F4 or 0x00FE, changes no output.
- R2: After reset all three registers read 0. The CPU then sees ROM 0 at 0x0000, bank 0 at 0xC000, no overlay pages, the dock bank selected and video bank 0.
- R3: Without an overlay, memSel codes RAM as 0, ROM as 1 and external as 2. Addresses 0x0000–0x3FFF go to ROM (memSel=1) with physAddr = home bit 4 × 0x4000 + address. 0x4000–0x7FFF goes to bank 5, 0x8000–0xBFFF to bank 2 and 0xC000–0xFFFF to the bank in home bits 2:0. Home bits 7:5 have no effect.
- R4: A home RAM bank b at offset o within its 16K window maps to physAddr = 0x20000 + slot(b) × 0x4000 + o. The slots are filled by banks 6, 4, 2, 0, 1, 3, 5, 7, in that order.
- R5: When bit n of the overlay register is set, CPU page n (address bits 15:13 equal to n) maps to RAM at physAddr = B × 0x10000 + n × 0x2000 + (address mod 0x2000). Here B is control bit 7.
- R6: Control bit 7 selects dock (0) or ex (1) for every overlaid page at once, so pages from both overlay banks are never mapped together.
- R7: rdData returns the last full byte written to the register addressed by portAddr, all eight bits, including the control register. It returns 0 for any other port.
- R8: vidBank equals home bit 3 and follows nothing else. Overlay and control writes leave it unchanged.
- R9: With extLow high, addresses 0x0000–0x3FFF give memSel=2 and physAddr = address. This holds even when those pages are overlaid.
- R10: memWe follows cpuWr except when memSel is ROM, where it stays 0.
- R11: A register write takes effect from the clock edge that samples ioWr. The translation is combinational in the CPU address and extLow.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuAddr | input | 16 | CPU memory address |
| cpuWr | input | 1 | CPU memory write request |
| extLow | input | 1 | Hands the low 16K to external memory |
| ioWr | input | 1 | I/O write strobe |
| portAddr | input | 16 | I/O port address, also selects readback |
| dataIn | input | 8 | I/O write data |
| physAddr | output | 18 | Physical address |
| memSel | output | 2 | Target: 0 RAM, 1 ROM, 2 external |
| memWe | output | 1 | Physical write enable |
| vidBank | output | 1 | Video fetch bank: 0 bank 5, 1 bank 7 |
| rdData | output | 8 | Readback of the addressed paging register |

## Verification
All translation outputs (physAddr, memSel, memWe) and rdData are combinational in the current inputs. They are due in the same cycle as the address or port is presented. A register write appears in those outputs, and in vidBank, one clock edge after ioWr is sampled.

The bench holds each stimulus for a full cycle and compares against its reference model at the falling edge. Its model registers are updated only after the rising edge that the hardware itself uses.

// File: rtl/pager_pkg.sv
package pager_pkg;
  localparam logic [15:0] PORT_OVL  = 16'h00F4;
  localparam logic [15:0] PORT_CTL  = 16'h00FF;
  localparam logic [15:0] PORT_HOME = 16'h7FFD;

  typedef enum logic [1:0] {
    SEL_RAM = 2'd0,
    SEL_ROM = 2'd1,
    SEL_EXT = 2'd2
  } memSel_e;

  typedef struct packed {
    logic wrOvl;
    logic wrCtl;
    logic wrHome;
    logic rdOvl;
    logic rdCtl;
    logic rdHome;
  } strobe_t;
endpackage

// File: rtl/pager_decode.sv
module pager_decode
  import pager_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              ioWr,
  input  logic [PORT_W-1:0] portAddr,
  output strobe_t           strobe
);
  logic hitOvl, hitCtl, hitHome;

  always_comb begin
    hitOvl  = (portAddr == PORT_W'(PORT_OVL));
    hitCtl  = (portAddr == PORT_W'(PORT_CTL));
    hitHome = (portAddr == PORT_W'(PORT_HOME));
    strobe.rdOvl  = hitOvl;
    strobe.rdCtl  = hitCtl;
    strobe.rdHome = hitHome;
    strobe.wrOvl  = ioWr & hitOvl;
    strobe.wrCtl  = ioWr & hitCtl;
    strobe.wrHome = ioWr & hitHome;
  end
endmodule

// File: rtl/pager_datapath.sv
module pager_datapath
  import pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 3,
  parameter int PHYS_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              extLow,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        memSel,
  output logic              memWe,
  output logic              vidBank,
  output logic [DATA_W-1:0] rdData
);
  localparam int NPAGE  = 1 << PAGE_W;
  localparam int OFFS_W = ADDR_W - PAGE_W;
  localparam int WIN_W  = ADDR_W - 2;

  logic [DATA_W-1:0] ovlReg, ctlReg, homeReg;

  // paging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlReg  <= '0;
      ctlReg  <= '0;
      homeReg <= '0;
    end else begin
      if (strobe.wrOvl)  ovlReg  <= dataIn;
      if (strobe.wrCtl)  ctlReg  <= dataIn;
      if (strobe.wrHome) homeReg <= dataIn;
    end
  end

  // readback mux
  always_comb begin
    rdData = '0;
    if (strobe.rdOvl)  rdData = ovlReg;
    if (strobe.rdCtl)  rdData = ctlReg;
    if (strobe.rdHome) rdData = homeReg;
  end

  // per-page overlay hit
  logic [PAGE_W-1:0] pageIdx;
  logic [NPAGE-1:0]  pageHit;
  assign pageIdx = cpuAddr[ADDR_W-1 -: PAGE_W];

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    assign pageHit[p] = ovlReg[p] & (pageIdx == PAGE_W'(p));
  end

  logic       ovlActive, lowWin, exBank;
  logic [2:0] homeBank, homeSlot;
  logic [1:0] winIdx;

  assign ovlActive = |pageHit;
  assign winIdx    = cpuAddr[ADDR_W-1 -: 2];
  assign lowWin    = (winIdx == 2'd0);
  assign exBank    = ctlReg[7];

  always_comb begin
    unique case (winIdx)
      2'd1:    homeBank = 3'd5;
      2'd2:    homeBank = 3'd2;
      default: homeBank = homeReg[2:0];
    endcase
    // slots hold banks 6,4,2,0,1,3,5,7
    homeSlot = homeBank[0] ? {1'b1, homeBank[2:1]} : {1'b0, ~homeBank[2:1]};
  end

  always_comb begin
    physAddr = '0;
    memSel   = SEL_RAM;
    if (extLow && lowWin) begin
      memSel   = SEL_EXT;
      physAddr = PHYS_W'(cpuAddr[WIN_W-1:0]);
    end else if (ovlActive) begin
      memSel   = SEL_RAM;
      physAddr = PHYS_W'({exBank, pageIdx, cpuAddr[OFFS_W-1:0]});
    end else if (lowWin) begin
      memSel   = SEL_ROM;
      physAddr = PHYS_W'({homeReg[4], cpuAddr[WIN_W-1:0]});
    end else begin
      memSel   = SEL_RAM;
      physAddr = PHYS_W'({1'b1, homeSlot, cpuAddr[WIN_W-1:0]});
    end
  end

  assign memWe   = cpuWr & (memSel != SEL_ROM);
  assign vidBank = homeReg[3];
endmodule

// File: rtl/bank_pager.sv
module bank_pager
  import pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 3,
  parameter int PHYS_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              extLow,
  input  logic              ioWr,
  input  logic [15:0]       portAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        memSel,
  output logic              memWe,
  output logic              vidBank,
  output logic [DATA_W-1:0] rdData
);
  strobe_t strobe;

  pager_decode #(.PORT_W(16)) u_decode (
    .ioWr     (ioWr),
    .portAddr (portAddr),
    .strobe   (strobe)
  );

  pager_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .cpuAddr  (cpuAddr),
    .cpuWr    (cpuWr),
    .extLow   (extLow),
    .physAddr (physAddr),
    .memSel   (memSel),
    .memWe    (memWe),
    .vidBank  (vidBank),
    .rdData   (rdData)
  );
endmodule

// File: rtl/bank_pager_chk.sv
module bank_pager_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuWr,
  input logic        extLow,
  input logic        ioWr,
  input logic [15:0] portAddr,
  input logic [7:0]  dataIn,
  input logic [17:0] physAddr,
  input logic [1:0]  memSel,
  input logic        memWe,
  input logic        vidBank,
  input logic [7:0]  rdData
);
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memSel == 2'd1) |-> !memWe); // R10

  AST_EXT_LOW_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (extLow && cpuAddr[15:14] == 2'b00) |-> (memSel == 2'd2 && physAddr == {4'b0, cpuAddr[13:0]})); // R9

  AST_VID_ONLY_HOME: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && portAddr == 16'h7FFD) |=> $stable(vidBank)); // R8

  AST_OVL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && portAddr == 16'h00F4) |=> (portAddr != 16'h00F4 || rdData == $past(dataIn))); // R7

  AST_BANK5_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b01 && physAddr[17]) |-> (memSel == 2'd0 && physAddr[16:14] == 3'd6)); // R4

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    memSel != 2'd3); // R3

  AST_UNDECODED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (portAddr != 16'h00F4 && portAddr != 16'h00FF && portAddr != 16'h7FFD) |-> rdData == 8'h00); // R1
endmodule

bind bank_pager bank_pager_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .extLow(extLow),
  .ioWr(ioWr), .portAddr(portAddr), .dataIn(dataIn), .physAddr(physAddr),
  .memSel(memSel), .memWe(memWe), .vidBank(vidBank), .rdData(rdData)
);

// File: tb/tb_bank_pager.sv
module tb_bank_pager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWr = 1'b0;
  logic        extLow = 1'b0;
  logic        ioWr = 1'b0;
  logic [15:0] portAddr = '0;
  logic [7:0]  dataIn = '0;
  logic [17:0] physAddr;
  logic [1:0]  memSel;
  logic        memWe;
  logic        vidBank;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  // reference model state
  int mOvl = 0, mCtl = 0, mHome = 0;
  int slotOrder[8] = '{6, 4, 2, 0, 1, 3, 5, 7};

  always #4 clk = ~clk;

  bank_pager dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .extLow(extLow),
    .ioWr(ioWr), .portAddr(portAddr), .dataIn(dataIn), .physAddr(physAddr),
    .memSel(memSel), .memWe(memWe), .vidBank(vidBank), .rdData(rdData)
  );

  function automatic int slotOf(int bank);
    for (int i = 0; i < 8; i++) if (slotOrder[i] == bank) return i;
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int a, page, sel, phys, bank, rd;
    a = cpuAddr;
    page = a / 'h2000;
    if (extLow && a < 'h4000) begin
      sel = 2; phys = a;
    end else if ((mOvl >> page) & 1) begin
      sel = 0; phys = ((mCtl >> 7) & 1) * 'h10000 + page * 'h2000 + a % 'h2000;
    end else if (a < 'h4000) begin
      sel = 1; phys = ((mHome >> 4) & 1) * 'h4000 + a;
    end else begin
      case (a / 'h4000)
        1: bank = 5;
        2: bank = 2;
        default: bank = mHome & 7;
      endcase
      sel = 0; phys = 'h20000 + slotOf(bank) * 'h4000 + a % 'h4000;
    end
    if (portAddr == 16'h00F4) rd = mOvl;
    else if (portAddr == 16'h00FF) rd = mCtl;
    else if (portAddr == 16'h7FFD) rd = mHome;
    else rd = 0;
    cmp(tag, "memSel", int'(memSel), sel);
    cmp(tag, "physAddr", int'(physAddr), phys);
    cmp(tag, "memWe R10", int'(memWe), (cpuWr && sel != 1) ? 1 : 0);
    cmp(tag, "vidBank R8", int'(vidBank), (mHome >> 3) & 1);
    cmp(tag, "rdData R7", int'(rdData), rd);
  endtask

  // one cycle: drive, check combinational outputs, clock, update model
  task automatic step(string tag, logic [15:0] a, logic w, logic ext,
                      logic iw, logic [15:0] port, logic [7:0] d);
    cpuAddr = a; cpuWr = w; extLow = ext; ioWr = iw; portAddr = port; dataIn = d;
    #1;
    checkAll(tag);
    @(posedge clk);
    if (iw) begin
      if (port == 16'h00F4) mOvl = d;
      else if (port == 16'h00FF) mCtl = d;
      else if (port == 16'h7FFD) mHome = d;
    end
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic wr(string tag, logic [15:0] port, logic [7:0] d);
    step(tag, 16'h0000, 1'b0, 1'b0, 1'b1, port, d);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    step("R2", 16'h0123, 1'b1, 1'b0, 1'b0, 16'h00F4, 8'h00);
    step("R2", 16'hC010, 1'b0, 1'b0, 1'b0, 16'h00FF, 8'h00);
    step("R2", 16'h5000, 1'b0, 1'b0, 1'b0, 16'h7FFD, 8'h00);
    // R3 home windows, bits 7:5 ignored
    wr("R3", 16'h7FFD, 8'hF3);
    step("R3", 16'hC001, 1'b1, 1'b0, 1'b0, 16'h7FFD, 8'h00);
    step("R3", 16'h3FFF, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);
    wr("R3", 16'h7FFD, 8'h10);
    step("R3", 16'h0042, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
    step("R3", 16'h8000, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);
    // R4 every home bank at 0xC000
    for (int b = 0; b < 8; b++) begin
      wr("R4", 16'h7FFD, 8'(b));
      step("R4", 16'hFFFF, 1'b1, 1'b0, 1'b0, 16'h7FFD, 8'h00);
    end
    // R8 video bank
    wr("R8", 16'h7FFD, 8'h08);
    wr("R8", 16'h00F4, 8'hFF);
    wr("R8", 16'h00FF, 8'hFF);
    step("R8", 16'h4000, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
    // R5 R6 overlay pages from dock then ex
    wr("R5", 16'h00F4, 8'h24);
    wr("R6", 16'h00FF, 8'h00);
    for (int p = 0; p < 8; p++)
      step("R5", 16'(p * 'h2000 + 'h123), 1'b1, 1'b0, 1'b0, 16'h00F4, 8'h00);
    wr("R6", 16'h00FF, 8'h80);
    step("R6", 16'h4567, 1'b1, 1'b0, 1'b0, 16'h00FF, 8'h00);
    step("R6", 16'hA567, 1'b1, 1'b0, 1'b0, 16'h00FF, 8'h00);
    // R9 external override beats overlay
    wr("R9", 16'h00F4, 8'h03);
    step("R9", 16'h2345, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00);
    step("R9", 16'h0345, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
    step("R9", 16'h4345, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00);
    // R1 partial-decode aliases ignored
    wr("R1", 16'h01F4, 8'h00);
    wr("R1", 16'h00FE, 8'h00);
    wr("R1", 16'hFFFD, 8'h55);
    step("R1", 16'h1000, 1'b0, 1'b0, 1'b0, 16'h00F4, 8'h00);
    step("R1", 16'hC000, 1'b0, 1'b0, 1'b0, 16'h7FFD, 8'h00);
    // R7 R11 random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] port;
      case ($urandom_range(0, 4))
        0: port = 16'h00F4;
        1: port = 16'h00FF;
        2: port = 16'h7FFD;
        3: port = 16'h80F4;
        default: port = 16'($urandom);
      endcase
      step("R11", 16'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom), port, 8'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule